// File: doc/BRIEF.md
# Key-Protected Routine Download Controller

This block copies one of two built-in routines (a program routine or an erase routine) from a hidden storage area into on-chip RAM when software asks for it. Software fills four byte-wide registers: an unlock key, a routine choice, and a target RAM address. It then sets a start bit. The start bit is accepted only when the unlock value is present and the write comes from code executing out of on-chip RAM. Once accepted, the transfer runs with no further command.

While the transfer runs, a bank-switch output maps the routine storage in place of user flash. The controller checks the choice and the target, and then either copies the routine or skips the copy. It restores the normal mapping, and as its final action it writes a one-byte outcome code at the target address. The outcome reaches software through RAM, not through a status register. Completion clears the routine choice and the start bit. Software presets the target byte to 0xFF so that it can tell whether an outcome has been written.

The routine length (`LEN`) and the RAM address width (`RAM_AW`) are parameters. The routine copy lands just after the outcome byte, at target+1 through target+LEN.

Top module: `fdl_ctrl`

## Requirements
- R1: After reset, the key, choice, target and start registers all read 0, and `busy`, `bank_sw` and `ram_we` are low.
- R2: Register offsets and reads:
  - Offset 0 is the key register.
  - Offset 1 is the choice register: bit 0 selects the program routine and bit 1 selects the erase routine.
  - Offset 2 is the target register.
  - Offset 3 is control, with bit 0 as the start bit.
  - `reg_rdata` combinationally shows the register at `reg_addr`.
- R3: A write of 1 to the start bit while the key register holds anything other than 0xA5 is ignored: no transfer begins and the start bit stays 0.
- R4: A write of 1 to the start bit with `reg_from_ram` low is ignored.
- R5: An accepted start write raises `busy` in the next cycle. `bank_sw` is high only while busy, and it is low again in the cycle that writes the outcome byte.
- R6: With exactly one choice bit set and a valid target, routine byte i (i = 0..LEN-1) is written to target+1+i in ascending order. Byte i is (7*i + 0x05) mod 256 for the program routine and (7*i + 0x40) mod 256 for the erase routine. The outcome 0x01 is then written at the target.
- R7: When no choice bit or both choice bits are set, no routine byte is written, and outcome bit 1 is set (0x02).
- R8: A target above 2^RAM_AW - 1 - LEN sets outcome bit 2 (0x04) and nothing is copied; the target exactly at that limit is valid. With a bad choice as well, the outcome is 0x06. Unused outcome bits are 0.
- R9: At completion, the choice register and the start bit read 0. The key and target keep their values.
- R10: Register writes made while `busy` is high are ignored.
- R11: `busy` stays high for LEN+3 cycles on a successful transfer and for 3 cycles on an error. It falls in the cycle after the outcome byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_from_ram | input | 1 | High when the write originates from code executing in on-chip RAM |
| reg_rdata | output | 8 | Read data of the addressed register |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| bank_sw | output | 1 | High while routine storage replaces user flash |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume the following about the inputs:
- `reg_we`, `reg_addr`, `reg_wdata` and `reg_from_ram` are valid at every clock edge once reset is released.
- The target value written before a launch describes the intended RAM window.

The window check relies on the target staying constant while the transfer runs, and the bench tests this directly by writing a new target mid-transfer. The stimulus changes inputs only on falling edges and always holds the strobe for exactly one rising edge. It launches a new transfer only after `busy` has dropped.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_COPY,
    ST_RESTORE,
    ST_RESULT
  } fdl_state_e;

  localparam logic [7:0] KEY_OPEN = 8'hA5;

  localparam logic [1:0] OFS_KEY = 2'd0;
  localparam logic [1:0] OFS_SEL = 2'd1;
  localparam logic [1:0] OFS_TGT = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;

  localparam int RES_OK_BIT  = 0;
  localparam int RES_SEL_BIT = 1;
  localparam int RES_TGT_BIT = 2;

  function automatic logic [7:0] rom_byte(input logic erase, input int unsigned idx);
    logic [7:0] base;
    base = erase ? 8'h40 : 8'h05;
    return 8'(idx * 7) + base;
  endfunction

endpackage

// File: rtl/fdl_regs.sv
module fdl_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          from_ram,
  input  logic          busy,
  input  logic          clr,
  output logic [7:0]    key_q,
  output logic          sel_p_q,
  output logic          sel_e_q,
  output logic [AW-1:0] tgt_q,
  output logic          go_q,
  output logic          launch,
  output logic [7:0]    rdata
);
  import fdl_pkg::*;

  logic          wr_ok;
  logic          key_en, sel_en, tgt_en, go_en;
  logic [7:0]    key_d;
  logic          sel_p_d, sel_e_d, go_d;
  logic [AW-1:0] tgt_d;

  always_comb begin
    wr_ok   = we && !busy;
    launch  = wr_ok && (addr == OFS_CTL) && wdata[0] && (key_q == KEY_OPEN) && from_ram;
    key_en  = wr_ok && (addr == OFS_KEY);
    key_d   = wdata;
    tgt_en  = wr_ok && (addr == OFS_TGT);
    tgt_d   = AW'(wdata);
    sel_en  = clr || (wr_ok && (addr == OFS_SEL));
    sel_p_d = clr ? 1'b0 : wdata[0];
    sel_e_d = clr ? 1'b0 : wdata[1];
    go_en   = clr || launch;
    go_d    = !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      sel_p_q <= 1'b0;
      sel_e_q <= 1'b0;
      tgt_q   <= '0;
      go_q    <= 1'b0;
    end else begin
      if (key_en) key_q <= key_d;
      if (sel_en) begin
        sel_p_q <= sel_p_d;
        sel_e_q <= sel_e_d;
      end
      if (tgt_en) tgt_q <= tgt_d;
      if (go_en)  go_q  <= go_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_KEY: rdata = key_q;
      OFS_SEL: rdata = {6'b0, sel_e_q, sel_p_q};
      OFS_TGT: rdata = 8'(tgt_q);
      default: rdata = {7'b0, go_q};
    endcase
  end

endmodule

// File: rtl/fdl_rom.sv
module fdl_rom #(
  parameter int LEN = 16,
  parameter int IW  = 4
) (
  input  logic          erase,
  input  logic [IW-1:0] idx,
  output logic [7:0]    data
);
  import fdl_pkg::*;

  logic [7:0] prog_tab [LEN];
  logic [7:0] ers_tab  [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_tab
    assign prog_tab[i] = rom_byte(1'b0, i);
    assign ers_tab[i]  = rom_byte(1'b1, i);
  end

  always_comb begin
    data = erase ? ers_tab[idx] : prog_tab[idx];
  end

endmodule

// File: rtl/fdl_seq.sv
module fdl_seq #(
  parameter int LEN = 16,
  parameter int AW  = 8,
  parameter int IW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          sel_p,
  input  logic          sel_e,
  input  logic [AW-1:0] tgt,
  input  logic [7:0]    rom_data,
  output logic [IW-1:0] rom_idx,
  output logic          rom_erase,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          bank_sw,
  output logic          busy,
  output logic          clr
);
  import fdl_pkg::*;

  localparam int          DEPTH   = 1 << AW;
  localparam int          MAX_TGT = DEPTH - 1 - LEN;
  localparam logic [AW:0] MAX_T   = (AW+1)'(MAX_TGT);
  localparam logic [IW-1:0] LAST  = IW'(LEN - 1);

  fdl_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [7:0]    code_q, code_d;
  logic          idx_en, code_en;
  logic          sel_bad, tgt_bad;

  always_comb begin
    sel_bad = !(sel_p ^ sel_e);
    tgt_bad = {1'b0, tgt} > MAX_T;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    code_d  = code_q;
    code_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (launch) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        code_en = 1'b1;
        code_d  = '0;
        code_d[RES_SEL_BIT] = sel_bad;
        code_d[RES_TGT_BIT] = tgt_bad;
        code_d[RES_OK_BIT]  = !sel_bad && !tgt_bad;
        idx_en  = 1'b1;
        idx_d   = '0;
        state_d = (sel_bad || tgt_bad) ? ST_RESTORE : ST_COPY;
      end
      ST_COPY: begin
        idx_en = 1'b1;
        idx_d  = idx_q + IW'(1);
        if (idx_q == LAST) state_d = ST_RESTORE;
      end
      ST_RESTORE: state_d = ST_RESULT;
      ST_RESULT:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx_q  <= idx_d;
      if (code_en) code_q <= code_d;
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    bank_sw   = (state_q == ST_CHECK) || (state_q == ST_COPY);
    clr       = (state_q == ST_RESULT);
    rom_idx   = idx_q;
    rom_erase = sel_e;
    ram_we    = 1'b0;
    ram_addr  = tgt;
    ram_wdata = code_q;
    if (state_q == ST_COPY) begin
      ram_we    = 1'b1;
      ram_addr  = tgt + AW'(idx_q) + AW'(1);
      ram_wdata = rom_data;
    end else if (state_q == ST_RESULT) begin
      ram_we    = 1'b1;
    end
  end

endmodule

// File: rtl/fdl_ctrl.sv
module fdl_ctrl #(
  parameter int LEN    = 16,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_from_ram,
  output logic [7:0]        reg_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              bank_sw,
  output logic              busy
);
  localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [1:0]        rst_sync;
  logic              srst_n;
  logic [7:0]        key_q;
  logic              sel_p_q, sel_e_q, go_q;
  logic [RAM_AW-1:0] tgt_q;
  logic              launch, clr;
  logic [IW-1:0]     rom_idx;
  logic              rom_erase;
  logic [7:0]        rom_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  fdl_regs #(.AW(RAM_AW)) u_regs (
    .clk(clk), .rst_n(srst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .from_ram(reg_from_ram), .busy(busy), .clr(clr), .key_q(key_q),
    .sel_p_q(sel_p_q), .sel_e_q(sel_e_q), .tgt_q(tgt_q), .go_q(go_q),
    .launch(launch), .rdata(reg_rdata)
  );

  fdl_rom #(.LEN(LEN), .IW(IW)) u_rom (
    .erase(rom_erase), .idx(rom_idx), .data(rom_data)
  );

  fdl_seq #(.LEN(LEN), .AW(RAM_AW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(srst_n), .launch(launch), .sel_p(sel_p_q), .sel_e(sel_e_q),
    .tgt(tgt_q), .rom_data(rom_data), .rom_idx(rom_idx), .rom_erase(rom_erase),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .bank_sw(bank_sw), .busy(busy), .clr(clr)
  );

endmodule

// File: rtl/fdl_ctrl_chk.sv
module fdl_ctrl_chk #(
  parameter int LEN    = 16,
  parameter int RAM_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bank_sw,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr,
  input logic [RAM_AW-1:0] tgt_q,
  input logic [7:0]        key_q,
  input logic              go_q,
  input logic              sel_p_q,
  input logic              sel_e_q,
  input logic              reg_we,
  input logic              reg_from_ram
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_we && !bank_sw));

  a_r5_bank_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sw |-> busy);

  a_r3_r4_launch_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_from_ram && (key_q == 8'hA5)));

  a_r11_ends_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ram_we && !bank_sw));

  a_r9_cleared_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!go_q && !sel_p_q && !sel_e_q));

  a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(tgt_q) && $stable(key_q)));

  a_r6_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_addr - tgt_q) <= RAM_AW'(LEN)));

endmodule

bind fdl_ctrl fdl_ctrl_chk #(.LEN(LEN), .RAM_AW(RAM_AW)) u_chk (
  .clk(clk), .rst_n(srst_n), .busy(busy), .bank_sw(bank_sw), .ram_we(ram_we),
  .ram_addr(ram_addr), .tgt_q(tgt_q), .key_q(key_q), .go_q(go_q),
  .sel_p_q(sel_p_q), .sel_e_q(sel_e_q), .reg_we(reg_we), .reg_from_ram(reg_from_ram)
);

// File: tb/sim_fdl_ctrl.sv
module sim_fdl_ctrl;
  localparam int LEN = 16;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [7:0]    reg_wdata = 8'd0;
  logic          reg_from_ram = 1'b0;
  logic [7:0]    reg_rdata;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;
  logic          bank_sw;
  logic          busy;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  logic [15:0] expq[$];

  always #5 clk = ~clk;

  fdl_ctrl #(.LEN(LEN), .RAM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_from_ram(reg_from_ram), .reg_rdata(reg_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .bank_sw(bank_sw), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rom(input bit erase, input int i);
    return 8'(7 * i + (erase ? 8'h40 : 8'h05));
  endfunction

  // scoreboard monitor: every RAM write is popped and compared
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (expq.size() == 0) begin
        check(1'b0, cur_req, {ram_addr, ram_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        check({ram_addr, ram_wdata} == e, cur_req, {ram_addr, ram_wdata}, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic fr);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_from_ram = fr;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic run_dl(input logic [1:0] sel, input logic [7:0] tgt,
                        input logic [7:0] code, input bit intrude, input string req);
    int n;
    bit saw_bank;
    bit last_bank;
    wr(2'd0, 8'hA5, 1'b1);
    wr(2'd1, {6'b0, sel}, 1'b1);
    wr(2'd2, tgt, 1'b1);
    cur_req = req;
    if (code == 8'h01)
      for (int i = 0; i < LEN; i++)
        expq.push_back({8'(tgt + 1 + i), exp_rom(sel[1], i)});
    expq.push_back({tgt, code});
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h01; reg_from_ram = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    check(busy == 1'b1, "R5 busy after launch", busy, 1);
    n = 0; saw_bank = 0; last_bank = 1;
    while (busy && n < 1000) begin
      n++;
      if (bank_sw) saw_bank = 1;
      last_bank = bank_sw;
      if (intrude && n == 2) begin
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h33; reg_from_ram = 1'b1;
      end else begin
        reg_we = 1'b0;
      end
      @(negedge clk);
    end
    reg_we = 1'b0;
    check(n == ((code == 8'h01) ? LEN + 3 : 3), "R11 busy length", n,
          (code == 8'h01) ? LEN + 3 : 3);
    check(saw_bank, "R5 bank switched", saw_bank, 1);
    check(last_bank == 1'b0, "R5 bank restored before outcome", last_bank, 0);
    check(expq.size() == 0, {req, " all writes seen"}, expq.size(), 0);
    rd_chk(2'd1, 8'h00, "R9 choice cleared");
    rd_chk(2'd3, 8'h00, "R9 start cleared");
    rd_chk(2'd0, 8'hA5, "R9 key kept");
    rd_chk(2'd2, tgt, intrude ? "R10 target untouched" : "R9 target kept");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(bank_sw == 1'b0, "R1 bank_sw", bank_sw, 0);
    rd_chk(2'd0, 8'h00, "R1 key");
    rd_chk(2'd1, 8'h00, "R1 choice");
    rd_chk(2'd2, 8'h00, "R1 target");
    rd_chk(2'd3, 8'h00, "R1 start");
    // R2 register map
    wr(2'd0, 8'h3C, 1'b0); rd_chk(2'd0, 8'h3C, "R2 key readback");
    wr(2'd1, 8'h03, 1'b0); rd_chk(2'd1, 8'h03, "R2 choice readback");
    wr(2'd2, 8'h55, 1'b0); rd_chk(2'd2, 8'h55, "R2 target readback");
    // R3 wrong key
    cur_req = "R3";
    wr(2'd1, 8'h01, 1'b1);
    wr(2'd3, 8'h01, 1'b1);
    check(busy == 1'b0, "R3 no launch", busy, 0);
    rd_chk(2'd3, 8'h00, "R3 start stays 0");
    // R4 wrong origin
    cur_req = "R4";
    wr(2'd0, 8'hA5, 1'b1);
    wr(2'd3, 8'h01, 1'b0);
    check(busy == 1'b0, "R4 no launch", busy, 0);
    rd_chk(2'd3, 8'h00, "R4 start stays 0");
    // R6 successful transfers, R10 intrusion
    run_dl(2'b01, 8'h20, 8'h01, 1'b1, "R6 program copy");
    run_dl(2'b10, 8'(256 - 1 - LEN), 8'h01, 1'b0, "R8 limit target erase copy");
    // R7 selection errors
    run_dl(2'b00, 8'h10, 8'h02, 1'b0, "R7 no choice");
    run_dl(2'b11, 8'h10, 8'h02, 1'b0, "R7 both chosen");
    // R8 target errors
    run_dl(2'b01, 8'(256 - LEN), 8'h04, 1'b0, "R8 target over limit");
    run_dl(2'b11, 8'hFA, 8'h06, 1'b0, "R8 both errors");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule